// File: doc/BRIEF.md
# Serial Channel Word Buffer with Fill and Error Status

This block is the word buffer for one channel of a serial port. A direction setting picks its role. In transmit mode, the core writes words into it and the serial side drains them. In receive mode, the serial side fills it and the core reads the words out. The shift register itself is not part of the block. The handoff to it is a single-cycle word event. When frame sync is required, that event is a frame-sync pulse, whether the pulse comes from an internal or an external source. When frame sync is not required, the event is a word-slot tick.

The buffer holds DEPTH words, two by default. It reports a two-bit fill code and a sticky error flag. In transmit mode the flag marks an underflow: the serial side asked for a word and the buffer was empty. In receive mode it marks an overflow: a word arrived and the buffer was full. A receive overflow replaces the newest stored word instead of dropping the arrival. A transmit underflow hands the serial side a zero word. Writing the direction setting empties the buffer and clears the flag.

Top module: `serial_chan_buffer`

## Requirements
- R1: After reset, the block is in receive mode (dirMode = 0). The fill code is 00, errFlag is 0 and shiftOutValid is 0.
- R2: The fill code is 00 when no word is stored, 11 when DEPTH words are stored, and 10 for any count in between. The code 01 never appears.
- R3: In transmit mode (dirMode = 1), a core write stores coreWrData unless the buffer is full at the start of that cycle. A write to a full buffer is discarded. Core reads have no effect.
- R4: In transmit mode, a word event on a non-empty buffer removes the oldest word. That word appears on shiftOutData, with shiftOutValid high for one cycle, in the cycle after the event. Words leave in the order they were written.
- R5: In transmit mode, a word event on an empty buffer is an underflow. On the next cycle, shiftOutValid is high and shiftOutData is 0, and errFlag sets. The event removes nothing. A core write in the same cycle is still stored.
- R6: In receive mode, a word event on a buffer that is not full stores shiftInData. While the buffer is not empty, coreRdData shows the oldest word; otherwise coreRdData is 0. A core read removes the oldest word, and a read on an empty buffer does nothing. Core writes have no effect. A read and an event in the same cycle both take effect.
- R7: In receive mode, a word event on a full buffer is an overflow. errFlag sets, the newest stored word is replaced by shiftInData, and the count does not change.
- R8: With needSync = 1, only frameSync pulses count as word events and slotTick is ignored. With needSync = 0, only slotTick counts as a word event and frameSync is ignored.
- R9: errFlag stays set until reset or a direction write. A direction write loads dirValue into dirMode, empties the buffer and clears errFlag.
- R10: In a cycle with a direction write, core writes, core reads and word events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirWrite | input | 1 | Direction write strobe |
| dirValue | input | 1 | New direction: 1 transmit, 0 receive |
| needSync | input | 1 | 1: frame-sync pulses are word events; 0: slot ticks are |
| frameSync | input | 1 | Frame-sync pulse |
| slotTick | input | 1 | Word-slot tick |
| coreWrEn | input | 1 | Core write strobe |
| coreWrData | input | W | Core write word |
| coreRdEn | input | 1 | Core read strobe (pops the oldest word) |
| coreRdData | output | W | Oldest stored word in receive mode, else 0 |
| shiftInData | input | W | Word delivered by the receive shift register |
| shiftOutData | output | W | Word handed to the transmit shift register |
| shiftOutValid | output | 1 | One-cycle strobe for shiftOutData |
| dirMode | output | 1 | Current direction |
| fillStatus | output | 2 | Fill code 00/10/11 |
| errFlag | output | 1 | Sticky underflow/overflow flag |

## Verification
In transmit mode, the bench fills the buffer past its capacity and drains it with frame-sync pulses until it underflows. It also writes during a drain event, which separates the "count at start of cycle" rule from an ordering that would read the buffer after the write. In receive mode, it overflows the buffer and then reads during an overflow event. This shows that the newest word is replaced rather than the oldest, and that the read and the event both take effect in the same cycle. The bench gives each event source while the other one is selected, to confirm it is ignored. It also gives core actions in a direction-write cycle, and checks the error flag across repeated underflows and after a direction change.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam logic [1:0] FILL_EMPTY = 2'b00;
  localparam logic [1:0] FILL_PART  = 2'b10;
  localparam logic [1:0] FILL_FULL  = 2'b11;

  // one-cycle actions that the control requests from the datapath
  typedef struct packed {
    logic clear;      // empty the buffer
    logic push;       // store a word at the tail
    logic overwrite;  // replace the newest word
    logic pop;        // drop the oldest word
    logic txLoad;     // hand the oldest word to the shift side
    logic txZero;     // hand a zero word to the shift side
    logic selCore;    // word source: 1 core, 0 shift side
  } bufStrobes_t;

endpackage

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirWrite,
  input  logic          dirValue,
  input  logic          needSync,
  input  logic          frameSync,
  input  logic          slotTick,
  input  logic          coreWrEn,
  input  logic          coreRdEn,
  input  logic [CW-1:0] count,
  output bufStrobes_t   strobes,
  output logic          dirMode,
  output logic          errFlag,
  output logic [1:0]    fillStatus
);

  logic wordEvent;
  logic isEmpty;
  logic isFull;
  logic errSet;

  assign wordEvent = needSync ? frameSync : slotTick;
  assign isEmpty   = (count == '0);
  assign isFull    = (count == CW'(DEPTH));

  always_comb begin
    strobes = '0;
    if (dirWrite) begin
      strobes.clear = 1'b1;
    end else if (dirMode) begin
      strobes.selCore = 1'b1;
      strobes.txLoad  = wordEvent && !isEmpty;
      strobes.txZero  = wordEvent && isEmpty;
      strobes.pop     = wordEvent && !isEmpty;
      strobes.push    = coreWrEn && !isFull;
    end else begin
      strobes.push      = wordEvent && !isFull;
      strobes.overwrite = wordEvent && isFull;
      strobes.pop       = coreRdEn && !isEmpty;
    end
  end

  assign errSet = strobes.txZero || strobes.overwrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirMode <= 1'b0;
      errFlag <= 1'b0;
    end else if (dirWrite) begin
      dirMode <= dirValue;
      errFlag <= 1'b0;
    end else if (errSet) begin
      errFlag <= 1'b1;
    end
  end

  always_comb begin
    if (isEmpty)     fillStatus = FILL_EMPTY;
    else if (isFull) fillStatus = FILL_FULL;
    else             fillStatus = FILL_PART;
  end

  assert_fill_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillStatus != 2'b01);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !dirWrite) |=> errFlag);

  assert_dir_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> (!errFlag && dirMode == $past(dirValue)));

  assert_tx_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dirWrite && dirMode && wordEvent && fillStatus == FILL_EMPTY) |=> errFlag);

  assert_rx_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dirWrite && !dirMode && wordEvent && fillStatus == FILL_FULL) |=> errFlag);

endmodule

// File: rtl/scb_datapath.sv
module scb_datapath
  import scb_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStrobes_t   strobes,
  input  logic          dirMode,
  input  logic [W-1:0]  coreWrData,
  input  logic [W-1:0]  shiftInData,
  output logic [W-1:0]  coreRdData,
  output logic [W-1:0]  shiftOutData,
  output logic          shiftOutValid,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] newestPtr;
  logic [W-1:0]  wrData;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign newestPtr  = (wrPtr == '0) ? PW'(DEPTH - 1) : wrPtr - 1'b1;
  assign wrData     = strobes.selCore ? coreWrData : shiftInData;
  assign coreRdData = (!dirMode && count != '0) ? mem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) begin
        mem[wrPtr] <= wrData;
        wrPtr <= nextPtr(wrPtr);
      end
      if (strobes.overwrite) mem[newestPtr] <= wrData;
      if (strobes.pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(strobes.push) - CW'(strobes.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftOutValid <= 1'b0;
      shiftOutData  <= '0;
    end else begin
      shiftOutValid <= strobes.txLoad || strobes.txZero;
      if (strobes.txLoad)      shiftOutData <= mem[rdPtr];
      else if (strobes.txZero) shiftOutData <= '0;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  assert_zero_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txZero |=> (shiftOutValid && shiftOutData == '0));

  assert_overwrite_keeps_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.overwrite && !strobes.pop) |=> $stable(count));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (count == '0));

endmodule

// File: rtl/serial_chan_buffer.sv
module serial_chan_buffer
  import scb_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dirWrite,
  input  logic         dirValue,
  input  logic         needSync,
  input  logic         frameSync,
  input  logic         slotTick,
  input  logic         coreWrEn,
  input  logic [W-1:0] coreWrData,
  input  logic         coreRdEn,
  output logic [W-1:0] coreRdData,
  input  logic [W-1:0] shiftInData,
  output logic [W-1:0] shiftOutData,
  output logic         shiftOutValid,
  output logic         dirMode,
  output logic [1:0]   fillStatus,
  output logic         errFlag
);

  localparam int CW = $clog2(DEPTH + 1);

  bufStrobes_t   strobes;
  logic [CW-1:0] count;

  scb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dirWrite   (dirWrite),
    .dirValue   (dirValue),
    .needSync   (needSync),
    .frameSync  (frameSync),
    .slotTick   (slotTick),
    .coreWrEn   (coreWrEn),
    .coreRdEn   (coreRdEn),
    .count      (count),
    .strobes    (strobes),
    .dirMode    (dirMode),
    .errFlag    (errFlag),
    .fillStatus (fillStatus)
  );

  scb_datapath #(.W(W), .DEPTH(DEPTH)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .dirMode       (dirMode),
    .coreWrData    (coreWrData),
    .shiftInData   (shiftInData),
    .coreRdData    (coreRdData),
    .shiftOutData  (shiftOutData),
    .shiftOutValid (shiftOutValid),
    .count         (count)
  );

endmodule

// File: tb/sim_serial_chan_buffer.sv
module sim_serial_chan_buffer;

  localparam int W = 16;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirWrite = 0, dirValue = 0, needSync = 1, frameSync = 0, slotTick = 0;
  logic coreWrEn = 0, coreRdEn = 0;
  logic [W-1:0] coreWrData = '0, shiftInData = '0;
  logic [W-1:0] coreRdData, shiftOutData;
  logic shiftOutValid, dirMode, errFlag;
  logic [1:0] fillStatus;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [W-1:0] q[$];
  logic mDir = 0, mErr = 0, mValid = 0;
  logic [W-1:0] mOut = '0;

  always #5 clk = ~clk;

  serial_chan_buffer #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .dirWrite(dirWrite), .dirValue(dirValue),
    .needSync(needSync), .frameSync(frameSync), .slotTick(slotTick),
    .coreWrEn(coreWrEn), .coreWrData(coreWrData), .coreRdEn(coreRdEn),
    .coreRdData(coreRdData), .shiftInData(shiftInData),
    .shiftOutData(shiftOutData), .shiftOutValid(shiftOutValid),
    .dirMode(dirMode), .fillStatus(fillStatus), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    int sz;
    logic ev;
    sz = q.size();
    if (!rstN) begin
      q.delete(); mDir = 0; mErr = 0; mValid = 0; mOut = '0;
      return;
    end
    if (dirWrite) begin
      mDir = dirValue; q.delete(); mErr = 0; mValid = 0;
      return;
    end
    ev = needSync ? frameSync : slotTick;
    if (mDir) begin
      mValid = ev;
      if (ev) begin
        if (sz > 0) mOut = q.pop_front();
        else begin mOut = '0; mErr = 1; end
      end
      if (coreWrEn && sz < DEPTH) q.push_back(coreWrData);
    end else begin
      mValid = 0;
      if (ev) begin
        if (sz < DEPTH) q.push_back(shiftInData);
        else begin mErr = 1; q[q.size()-1] = shiftInData; end
      end
      if (coreRdEn && sz > 0) void'(q.pop_front());
    end
  endtask

  task automatic compareAll(input string tag);
    int expFill, expRd;
    expFill = (q.size() == 0) ? 0 : (q.size() == DEPTH) ? 3 : 2;
    expRd = (!mDir && q.size() > 0) ? int'(q[0]) : 0;
    chk(tag, "fillStatus", int'(fillStatus), expFill);
    chk(tag, "errFlag", int'(errFlag), int'(mErr));
    chk(tag, "dirMode", int'(dirMode), int'(mDir));
    chk(tag, "coreRdData", int'(coreRdData), expRd);
    chk(tag, "shiftOutValid", int'(shiftOutValid), int'(mValid));
    if (mValid) chk(tag, "shiftOutData", int'(shiftOutData), int'(mOut));
  endtask

  task automatic idle();
    dirWrite = 0; frameSync = 0; slotTick = 0; coreWrEn = 0; coreRdEn = 0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(tag);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    modelStep();
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    chk("R1", "fill after reset", int'(fillStatus), 0);

    // direction write with other actions present: R10, R9
    dirWrite = 1; dirValue = 1; coreWrEn = 1; coreWrData = 16'h0bad; frameSync = 1;
    step("R10");
    chk("R10", "fill after dir write", int'(fillStatus), 0);

    coreWrEn = 1; coreWrData = 16'h1111; step("R3");
    coreWrEn = 1; coreWrData = 16'h2222; step("R2");
    chk("R2", "fill full code", int'(fillStatus), 3);
    coreWrEn = 1; coreWrData = 16'h3333; step("R3");
    coreRdEn = 1; step("R3");

    needSync = 1;
    slotTick = 1; step("R8");
    frameSync = 1; step("R4");
    chk("R4", "first word out", int'(shiftOutData), 16'h1111);
    frameSync = 1; coreWrEn = 1; coreWrData = 16'h4444; step("R4");
    chk("R4", "second word out", int'(shiftOutData), 16'h2222);
    frameSync = 1; step("R4");
    frameSync = 1; step("R5");
    chk("R5", "underflow zero word", int'(shiftOutData), 0);
    frameSync = 1; step("R9");
    coreWrEn = 1; coreWrData = 16'h5555; step("R9");
    step("R9");

    dirWrite = 1; dirValue = 1; step("R9");
    chk("R9", "err cleared", int'(errFlag), 0);
    needSync = 0;
    frameSync = 1; step("R8");
    chk("R8", "frameSync ignored", int'(errFlag), 0);
    coreWrEn = 1; coreWrData = 16'h6666; step("R3");
    slotTick = 1; step("R8");
    slotTick = 1; coreWrEn = 1; coreWrData = 16'h7777; step("R5");
    step("R5");

    dirWrite = 1; dirValue = 0; step("R9");
    needSync = 1;
    coreWrEn = 1; coreWrData = 16'h9999; step("R6");
    coreRdEn = 1; step("R6");
    frameSync = 1; shiftInData = 16'ha0a0; step("R6");
    chk("R6", "first rx word shown", int'(coreRdData), 16'ha0a0);
    frameSync = 1; shiftInData = 16'hb1b1; step("R6");
    frameSync = 1; shiftInData = 16'hc2c2; step("R7");
    coreRdEn = 1; step("R7");
    chk("R7", "newest overwritten", int'(coreRdData), 16'hc2c2);
    frameSync = 1; shiftInData = 16'hd3d3; coreRdEn = 1; step("R6");
    frameSync = 1; shiftInData = 16'he4e4; step("R6");
    frameSync = 1; shiftInData = 16'hf5f5; coreRdEn = 1; step("R7");
    chk("R7", "read with overflow", int'(coreRdData), 16'hf5f5);
    slotTick = 1; shiftInData = 16'h0101; step("R8");
    needSync = 0;
    slotTick = 1; shiftInData = 16'h1234; step("R8");
    frameSync = 1; shiftInData = 16'h4321; step("R8");
    coreRdEn = 1; step("R6");
    coreRdEn = 1; step("R6");
    coreRdEn = 1; step("R6");
    chk("R6", "empty read data", int'(coreRdData), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule